// File: doc/BRIEF.md
# Cartridge Interrupt Controller with Cycle Timer

This block combines four interrupt sources into a single active-low interrupt line for the host CPU of a game cartridge. The four sources are a 16-bit down-counter of host CPU cycles, an 8-bit raster timer that counts scanline ticks from an external sequencer, and the receive-done and transmit-done strobes of a serial port. The host sees a small register window on an 8-bit bus. Through it the host sets per-source enables, reads which sources have fired, clears pending requests, loads both timers, and locks the raster timer to vertical blank.

The enable register and the status register share one offset. A write to that offset sets the enables, and a read from it returns the status. The raster timer runs free until the host writes the frame-lock register. After that write, every vertical-blank strobe restarts the raster count. The serial port, the scanline sequencer and any bank switching live outside this block and connect only through single-cycle strobes.

Top module: `cart_irq_ctrl`

## Requirements
- R1: After reset, every enable and status bit is 0, both timer counts are 0, the raster timer is unlocked and irq_n is 1.
- R2: A write at offset 0 sets the enables from data bits [3:0]. Bit 0 enables the raster source, bit 1 the cycle source, bit 2 serial receive-done and bit 3 serial transmit-done. Data bits [7:4] have no effect.
- R3: A read at offset 0 returns the status in the same bit positions as R2, with bits [7:4] reading 0. A read at any other offset returns 0.
- R4: When a source produces an event, its status bit is set only if its enable bit is 1 in that cycle.
- R5: irq_n is 0 exactly when some status bit and its matching enable bit are both 1.
- R6: Any write at offset 1 clears all status bits, whatever data is written. An event in the same cycle as that write still sets its bit.
- R7: A write at offset 3 holds the low byte of the cycle count. A write at offset 4 supplies the high byte, loads the full 16-bit value and restarts the count. Each cpu_ce pulse decrements a nonzero count. The pulse that takes the count from 1 to 0 is the cycle event, so the event arrives exactly N pulses after loading N. At 0 the counter stops, and a load of 0 never produces an event.
- R8: A write at offset 5 sets the 8-bit raster reload value and the raster count. Each line_tick decrements a nonzero count. The tick that takes the count from 1 to 0 is the raster event, and it reloads the count, so events repeat every N ticks. A reload value of 0 produces no events.
- R9: Until the first write at offset 2, vblank has no effect on the raster count, so the raster timer runs free.
- R10: After any write at offset 2, whatever its data, each vblank pulse reloads the raster count from the reload value. A line_tick in the same cycle is ignored.
- R11: Clearing an enable bit takes irq_n back to 1 without changing the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Register window select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cpu_ce | input | 1 | One pulse per host CPU cycle |
| line_tick | input | 1 | One pulse per scanline |
| vblank | input | 1 | Vertical-blank strobe |
| rx_done | input | 1 | Serial byte received strobe |
| tx_done | input | 1 | Serial byte sent strobe |
| irq_n | output | 1 | Active-low interrupt request to the host |

## Verification
The cycle timer is swept over every load value from 1 to 24 plus one value with a nonzero high byte. The bench checks that the event is absent after N-1 pulses and present after N, which catches off-by-one and byte-order faults. The raster timer is swept over reload values 1 to 6 for three periods each, which separates one-shot from periodic behaviour. A partial count interrupted by vblank, run before and after the frame-lock write, separates free-running from locked operation. All sixteen enable masks are applied with every source firing at once, which exposes any mix-up between enable or status bit positions. A separate case covers an acknowledge that arrives in the same cycle as an event.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

   localparam int NUM_SRC  = 4;
   localparam int SRC_LINE = 0;
   localparam int SRC_CYC  = 1;
   localparam int SRC_RX   = 2;
   localparam int SRC_TX   = 3;

   typedef struct packed {
      logic mask_wr;
      logic ack_wr;
      logic sync_wr;
      logic cyc_lo_wr;
      logic cyc_hi_wr;
      logic line_wr;
      logic stat_rd;
   } cirq_sel_t;

endpackage

// File: rtl/cirq_decode.sv
module cirq_decode
   import cirq_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int OFS_MASK = 0,
   parameter int OFS_ACK  = 1,
   parameter int OFS_SYNC = 2,
   parameter int OFS_CLO  = 3,
   parameter int OFS_CHI  = 4,
   parameter int OFS_LINE = 5
) (
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output cirq_sel_t         sel
);

   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
   localparam logic [ADDR_W-1:0] A_SYNC = ADDR_W'(OFS_SYNC);
   localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(OFS_CLO);
   localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(OFS_CHI);
   localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFS_LINE);

   logic wr, rd;

   always_comb begin
      wr            = cs & we;
      rd            = cs & ~we;
      sel.mask_wr   = wr && (addr == A_MASK);
      sel.ack_wr    = wr && (addr == A_ACK);
      sel.sync_wr   = wr && (addr == A_SYNC);
      sel.cyc_lo_wr = wr && (addr == A_CLO);
      sel.cyc_hi_wr = wr && (addr == A_CHI);
      sel.line_wr   = wr && (addr == A_LINE);
      sel.stat_rd   = rd && (addr == A_MASK);
   end

endmodule

// File: rtl/cirq_cycle_timer.sv
module cirq_cycle_timer #(
   parameter int DATA_W = 8,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic              lo_wr,
   input  logic              hi_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              evt_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [DATA_W-1:0] lo_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (lo_wr)
            lo_q <= wdata;
         if (hi_wr)
            cnt_q <= {wdata, lo_q};
         else if (ce && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
      end
   end

   assign evt_o = ce && (cnt_q == ONE) && !hi_wr;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/cirq_raster_timer.sv
module cirq_raster_timer #(
   parameter int LINE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              vblank,
   input  logic              sync_wr,
   input  logic              load_wr,
   input  logic [LINE_W-1:0] wdata,
   output logic [LINE_W-1:0] cnt_o,
   output logic [LINE_W-1:0] reload_o,
   output logic              locked_o,
   output logic              evt_o
);

   localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

   logic [LINE_W-1:0] cnt_q, reload_q;
   logic              locked_q;
   logic              restart;

   assign restart = locked_q && vblank;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         reload_q <= '0;
         locked_q <= 1'b0;
      end else begin
         locked_q <= locked_q | sync_wr;
         if (load_wr) begin
            reload_q <= wdata;
            cnt_q    <= wdata;
         end else if (restart) begin
            cnt_q <= reload_q;
         end else if (tick && cnt_q != '0) begin
            cnt_q <= (cnt_q == ONE) ? reload_q : cnt_q - ONE;
         end
      end
   end

   assign evt_o    = tick && (cnt_q == ONE) && !load_wr && !restart;
   assign cnt_o    = cnt_q;
   assign reload_o = reload_q;
   assign locked_o = locked_q;

endmodule

// File: rtl/cirq_status.sv
module cirq_status #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            mask_wr,
   input  logic [NSRC-1:0] mask_d,
   input  logic            ack_wr,
   input  logic [NSRC-1:0] evt,
   output logic [NSRC-1:0] en_o,
   output logic [NSRC-1:0] stat_o
);

   logic [NSRC-1:0] en_q;

   always_ff @(posedge clk) begin
      if (rst)
         en_q <= '0;
      else if (mask_wr)
         en_q <= mask_d;
   end

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      logic flag_q;
      always_ff @(posedge clk) begin
         if (rst)
            flag_q <= 1'b0;
         else if (evt[k] && en_q[k])
            flag_q <= 1'b1;
         else if (ack_wr)
            flag_q <= 1'b0;
      end
      assign stat_o[k] = flag_q;
   end

   assign en_o = en_q;

endmodule

// File: rtl/cart_irq_ctrl.sv
module cart_irq_ctrl
   import cirq_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int LINE_W   = 8,
   parameter int OFS_MASK = 0,
   parameter int OFS_ACK  = 1,
   parameter int OFS_SYNC = 2,
   parameter int OFS_CLO  = 3,
   parameter int OFS_CHI  = 4,
   parameter int OFS_LINE = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_cs,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cpu_ce,
   input  logic              line_tick,
   input  logic              vblank,
   input  logic              rx_done,
   input  logic              tx_done,
   output logic              irq_n
);

   localparam int CNT_W = 2 * DATA_W;
   localparam int WIN   = 1 << ADDR_W;

   if (DATA_W < NUM_SRC) begin : g_bad_data
      $error("DATA_W must hold all status bits");
   end
   if (LINE_W > DATA_W) begin : g_bad_line
      $error("LINE_W must fit one bus write");
   end
   if (OFS_CHI != OFS_CLO + 1) begin : g_bad_pair
      $error("cycle high byte must sit right after the low byte");
   end
   if (OFS_MASK >= WIN || OFS_ACK >= WIN || OFS_SYNC >= WIN ||
       OFS_CLO >= WIN || OFS_CHI >= WIN || OFS_LINE >= WIN) begin : g_bad_ofs
      $error("register offset outside the window");
   end
   if (OFS_MASK == OFS_ACK || OFS_MASK == OFS_SYNC || OFS_MASK == OFS_CLO ||
       OFS_MASK == OFS_CHI || OFS_MASK == OFS_LINE || OFS_ACK == OFS_SYNC ||
       OFS_ACK == OFS_CLO || OFS_ACK == OFS_CHI || OFS_ACK == OFS_LINE ||
       OFS_SYNC == OFS_CLO || OFS_SYNC == OFS_CHI || OFS_SYNC == OFS_LINE ||
       OFS_CHI == OFS_LINE || OFS_CLO == OFS_LINE) begin : g_bad_dup
      $error("register offsets must be distinct");
   end

   cirq_sel_t          sel;
   logic [CNT_W-1:0]   cyc_cnt;
   logic [LINE_W-1:0]  sl_cnt, sl_reload;
   logic               sl_locked;
   logic [NUM_SRC-1:0] evt, en_q, stat_q;

   cirq_decode #(
      .ADDR_W(ADDR_W), .OFS_MASK(OFS_MASK), .OFS_ACK(OFS_ACK),
      .OFS_SYNC(OFS_SYNC), .OFS_CLO(OFS_CLO), .OFS_CHI(OFS_CHI),
      .OFS_LINE(OFS_LINE)
   ) u_dec (
      .cs(bus_cs), .we(bus_we), .addr(bus_addr), .sel(sel)
   );

   cirq_cycle_timer #(.DATA_W(DATA_W)) u_cyc (
      .clk(clk), .rst(rst), .ce(cpu_ce),
      .lo_wr(sel.cyc_lo_wr), .hi_wr(sel.cyc_hi_wr), .wdata(bus_wdata),
      .cnt_o(cyc_cnt), .evt_o(evt[SRC_CYC])
   );

   cirq_raster_timer #(.LINE_W(LINE_W)) u_line (
      .clk(clk), .rst(rst), .tick(line_tick), .vblank(vblank),
      .sync_wr(sel.sync_wr), .load_wr(sel.line_wr),
      .wdata(bus_wdata[LINE_W-1:0]),
      .cnt_o(sl_cnt), .reload_o(sl_reload), .locked_o(sl_locked),
      .evt_o(evt[SRC_LINE])
   );

   assign evt[SRC_RX] = rx_done;
   assign evt[SRC_TX] = tx_done;

   cirq_status #(.NSRC(NUM_SRC)) u_stat (
      .clk(clk), .rst(rst),
      .mask_wr(sel.mask_wr), .mask_d(bus_wdata[NUM_SRC-1:0]),
      .ack_wr(sel.ack_wr), .evt(evt),
      .en_o(en_q), .stat_o(stat_q)
   );

   assign irq_n = ~|(stat_q & en_q);

   if (DATA_W > NUM_SRC) begin : g_rd_pad
      assign bus_rdata = sel.stat_rd ? {{(DATA_W-NUM_SRC){1'b0}}, stat_q} : '0;
   end else begin : g_rd_exact
      assign bus_rdata = sel.stat_rd ? stat_q : '0;
   end

endmodule

// File: rtl/cirq_chk.sv
module cirq_chk #(
   parameter int ADDR_W   = 4,
   parameter int CNT_W    = 16,
   parameter int LINE_W   = 8,
   parameter int NSRC     = 4,
   parameter int OFS_ACK  = 1,
   parameter int OFS_CHI  = 4,
   parameter int OFS_LINE = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_cs,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              cpu_ce,
   input logic              line_tick,
   input logic              vblank,
   input logic              rx_done,
   input logic              tx_done,
   input logic              irq_n,
   input logic [NSRC-1:0]   en_q,
   input logic [NSRC-1:0]   stat_q,
   input logic [CNT_W-1:0]  cyc_cnt,
   input logic [LINE_W-1:0] sl_cnt,
   input logic [LINE_W-1:0] sl_reload,
   input logic              sl_locked
);

   logic ack_w, chi_w, line_w, any_evt;
   assign ack_w   = bus_cs && bus_we && (bus_addr == ADDR_W'(OFS_ACK));
   assign chi_w   = bus_cs && bus_we && (bus_addr == ADDR_W'(OFS_CHI));
   assign line_w  = bus_cs && bus_we && (bus_addr == ADDR_W'(OFS_LINE));
   assign any_evt = cpu_ce | line_tick | rx_done | tx_done;

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (en_q == '0 && stat_q == '0 && cyc_cnt == '0 &&
                      sl_cnt == '0 && !sl_locked && irq_n));

   // R4
   rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!en_q[2] && !stat_q[2]) |=> !stat_q[2]);

   // R5
   irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
      !irq_n |-> (stat_q != '0 && en_q != '0));

   // R6
   ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ack_w && !any_evt) |=> (stat_q == '0));

   // R7
   cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_ce && cyc_cnt != '0 && !chi_w) |=>
         (cyc_cnt == $past(cyc_cnt) - {{(CNT_W-1){1'b0}}, 1'b1}));

   // R7
   cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_cnt == '0 && !chi_w) |=> (cyc_cnt == '0));

   // R9
   free_run_chk: assert property (@(posedge clk) disable iff (rst)
      (!sl_locked && !line_tick && !line_w) |=> $stable(sl_cnt));

   // R10
   vblank_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (sl_locked && vblank && !line_w) |=> (sl_cnt == $past(sl_reload)));

endmodule

bind cart_irq_ctrl cirq_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W), .NSRC(cirq_pkg::NUM_SRC),
   .OFS_ACK(OFS_ACK), .OFS_CHI(OFS_CHI), .OFS_LINE(OFS_LINE)
) u_chk (
   .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
   .cpu_ce(cpu_ce), .line_tick(line_tick), .vblank(vblank),
   .rx_done(rx_done), .tx_done(tx_done), .irq_n(irq_n),
   .en_q(en_q), .stat_q(stat_q), .cyc_cnt(cyc_cnt), .sl_cnt(sl_cnt),
   .sl_reload(sl_reload), .sl_locked(sl_locked)
);

// File: tb/sim_cart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_cart_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_cs = 1'b0, bus_we = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cpu_ce = 1'b0, line_tick = 1'b0, vblank = 1'b0;
   logic       rx_done = 1'b0, tx_done = 1'b0;
   logic       irq_n;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cart_irq_ctrl u0 (
      .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_ce(cpu_ce), .line_tick(line_tick), .vblank(vblank),
      .rx_done(rx_done), .tx_done(tx_done), .irq_n(irq_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output int v);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
      #0.5;
      v = int'(bus_rdata);
      bus_cs = 1'b0;
   endtask

   task automatic ce_run(input int k);
      if (k > 0) begin
         cpu_ce = 1'b1;
         repeat (k) @(negedge clk);
         cpu_ce = 1'b0;
      end
   endtask

   task automatic ticks(input int k);
      if (k > 0) begin
         line_tick = 1'b1;
         repeat (k) @(negedge clk);
         line_tick = 1'b0;
      end
   endtask

   task automatic load_cyc(input int n);
      wr(4'd3, n[7:0]);
      wr(4'd4, n[15:8]);
   endtask

   initial begin
      repeat (50000) @(negedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      rd(4'd0, v);
      chk("R1 status", v, 0);
      chk("R1 irq_n", int'(irq_n), 1);

      // R9 free-running: vblank before any lock write is ignored
      wr(4'd0, 8'h01);
      wr(4'd5, 8'd4);
      ticks(2);
      vblank = 1'b1; @(negedge clk); vblank = 1'b0;
      ticks(1);
      rd(4'd0, v); chk("R9 before", v, 0);
      ticks(1);
      rd(4'd0, v); chk("R9 free event", v, 1);
      wr(4'd1, 8'h00);

      // R10 lock, then vblank restarts count; data of lock write ignored
      wr(4'd2, 8'h5A);
      wr(4'd5, 8'd4);
      ticks(2);
      vblank = 1'b1; line_tick = 1'b1; @(negedge clk);
      vblank = 1'b0; line_tick = 1'b0;
      ticks(3);
      rd(4'd0, v); chk("R10 restart no early event", v, 0);
      ticks(1);
      rd(4'd0, v); chk("R10 event after full period", v, 1);
      wr(4'd1, 8'hFF);

      // R8 raster period sweep
      for (int n = 1; n <= 6; n++) begin
         wr(4'd5, n[7:0]);
         for (int p = 0; p < 3; p++) begin
            ticks(n - 1);
            rd(4'd0, v); chk("R8 not yet", v, 0);
            ticks(1);
            rd(4'd0, v); chk("R8 period event", v, 1);
            wr(4'd1, 8'h00);
         end
      end
      wr(4'd5, 8'd0);
      ticks(300);
      rd(4'd0, v); chk("R8 zero reload silent", v, 0);

      // R7 cycle count sweep
      wr(4'd0, 8'h02);
      for (int n = 1; n <= 24; n++) begin
         load_cyc(n);
         ce_run(n - 1);
         rd(4'd0, v); chk("R7 not yet", v, 0);
         chk("R5 idle irq", int'(irq_n), 1);
         ce_run(1);
         rd(4'd0, v); chk("R7 event at N", v, 2);
         chk("R5 irq low", int'(irq_n), 0);
         wr(4'd1, 8'h00);
      end
      load_cyc(259);
      ce_run(258);
      rd(4'd0, v); chk("R7 16-bit not yet", v, 0);
      ce_run(1);
      rd(4'd0, v); chk("R7 16-bit event", v, 2);
      wr(4'd1, 8'h00);
      ce_run(10);
      rd(4'd0, v); chk("R7 one-shot stays idle", v, 0);
      load_cyc(0);
      ce_run(20);
      rd(4'd0, v); chk("R7 zero load silent", v, 0);

      // R2 R3 R4 R5 R11 mask sweep, every source fires at once
      for (int m = 0; m < 16; m++) begin
         wr(4'd0, {4'hA, m[3:0]});
         wr(4'd1, 8'h00);
         load_cyc(1);
         wr(4'd5, 8'd1);
         cpu_ce = 1'b1; line_tick = 1'b1; rx_done = 1'b1; tx_done = 1'b1;
         @(negedge clk);
         cpu_ce = 1'b0; line_tick = 1'b0; rx_done = 1'b0; tx_done = 1'b0;
         rd(4'd0, v); chk("R2 R4 status equals mask", v, m);
         chk("R5 irq vs mask", int'(irq_n), (m == 0) ? 1 : 0);
         rd(4'd3, v); chk("R3 other offset reads 0", v, 0);
         wr(4'd0, 8'h00);
         chk("R11 irq released", int'(irq_n), 1);
         rd(4'd0, v); chk("R11 status kept", v, m);
      end

      // R6 ack with any data, and event in same cycle wins
      wr(4'd0, 8'h04);
      rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
      wr(4'd1, 8'hFF);
      rd(4'd0, v); chk("R6 ack clears", v, 0);
      rx_done = 1'b1; wr(4'd1, 8'h00); rx_done = 1'b0;
      rd(4'd0, v); chk("R6 event beats ack", v, 4);
      chk("R6 irq after race", int'(irq_n), 0);

      // R1 reset again clears state
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      rd(4'd0, v); chk("R1 status after reset", v, 0);
      chk("R1 irq after reset", int'(irq_n), 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule